// File: doc/BRIEF.md
# Status Flag and Standby Wake Controller

This block keeps the one-bit status flag of a small 4-bit controller and decides when a halt puts the controller into standby and when standby ends. The instruction decoder delivers two single-cycle strobes: one for a status-test instruction and one for a halt instruction. Each strobe comes with a 4-bit operand. A shared condition selector reads that operand and tests key-input groups, the timer-zero indication and three auxiliary wake pins. The pins arrive already synchronised.

A status test loads the flag with the selected condition. A halt looks at the same condition and at the current flag. If the condition is already true, the flag is set and the controller keeps running. If the condition is false and the flag is 1, the flag is cleared and the controller keeps running. If the condition is false and the flag is 0, standby begins. The operand is then held, and the block watches that held condition until it becomes true. At that point it leaves standby and sets the flag.

Top module: `wake_flag_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives statusFlag and standby to 0.
- R2: When testStb is high outside standby, statusFlag takes the value of the condition selected by testOp at that edge. It becomes 1 if the condition is true and 0 otherwise, and the new value is visible after that edge.
- R3: The base condition comes from operand bits [2:0]. Code 3'b000 is true when any of keyIn[5:0] is high. Code 3'b011 is true when any of keyIn[2:0] is high. Code 3'b110 is true when any of keyIn[5:3] is high. Code 3'b101 is true when timerZero is high. Every other code is false.
- R4: When operand bit 3 is 1, the condition is also true if auxIn[0], auxIn[1] or the enabled auxIn[2] is high. This term is ORed with the base condition.
- R5: auxIn[2] contributes to the condition only while aux2Enable is 1.
- R6: A halt (haltStb high, testStb low, outside standby) whose condition is true sets statusFlag to 1 and leaves standby at 0.
- R7: A halt whose condition is false while statusFlag is 1 clears statusFlag to 0 and leaves standby at 0.
- R8: A halt whose condition is false while statusFlag is 0 raises standby at the next edge, and statusFlag stays 0.
- R9: During standby, the first edge at which the held condition is true lowers standby and raises statusFlag together.
- R10: The operand given with the halt that entered standby is held. Later values on haltOp or testOp do not change which condition ends standby.
- R11: While standby is 1, testStb and haltStb are ignored. statusFlag and standby do not change because of them.
- R12: If testStb and haltStb are both high in the same cycle outside standby, only the status test takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| testStb | input | 1 | Status-test instruction strobe |
| testOp | input | 4 | Operand of the status test |
| haltStb | input | 1 | Halt instruction strobe |
| haltOp | input | 4 | Operand of the halt |
| keyIn | input | KEY_W (6) | Key-input pins |
| auxIn | input | AUX_W (3) | Auxiliary wake pins S0..S2 |
| timerZero | input | 1 | High while the timer down counter is zero |
| aux2Enable | input | 1 | Enables auxIn[2] as a wake source |
| statusFlag | output | 1 | Status flag |
| standby | output | 1 | High while in standby |

## Verification
The hardest state to reach is a standby entered from a flag of 0 and then held while the live operand buses and strobes change. Getting there takes three steps. First, a status test with a false condition clears the flag. Next, a halt with a false condition enters standby. Then haltOp is switched to a condition that would be true, and strobes whose conditions would be true are fired. The bench checks that only the held condition, here the timer or the gated auxIn[2] with aux2Enable raised late, ends standby, and that the flag rises on that same edge.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
  localparam int OP_W   = 4;
  localparam int BASE_W = 3;

  localparam logic [BASE_W-1:0] CODE_KEY_ALL  = 3'b000;
  localparam logic [BASE_W-1:0] CODE_KEY_LOW  = 3'b011;
  localparam logic [BASE_W-1:0] CODE_KEY_HIGH = 3'b110;
  localparam logic [BASE_W-1:0] CODE_TIMER    = 3'b101;

  typedef enum logic [0:0] {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } wfcState_t;

  typedef struct packed {
    logic selLatched;
    logic selTest;
    logic loadOp;
  } wfcCtrl_t;
endpackage

// File: rtl/wfc_datapath.sv
module wfc_datapath
  import wfc_pkg::*;
#(
  parameter int KEY_W     = 6,
  parameter int KEY_SPLIT = 3,
  parameter int AUX_W     = 3,
  parameter int AUX_GATED = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  wfcCtrl_t         ctrl,
  input  logic [OP_W-1:0]  testOp,
  input  logic [OP_W-1:0]  haltOp,
  input  logic [KEY_W-1:0] keyIn,
  input  logic [AUX_W-1:0] auxIn,
  input  logic             timerZero,
  input  logic             aux2Enable,
  output logic             condTrue
);
  localparam int HIGH_W = KEY_W - KEY_SPLIT;

  logic [OP_W-1:0]   heldOp;
  logic [OP_W-1:0]   activeOp;
  logic [AUX_W-1:0]  auxEff;
  logic [BASE_W-1:0] baseCode;
  logic              keyAny;
  logic              keyLow;
  logic              keyHigh;
  logic              baseHit;
  logic              auxHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldOp <= '0;
    end else if (ctrl.loadOp) begin
      heldOp <= haltOp;
    end
  end

  always_comb begin
    if (ctrl.selLatched) begin
      activeOp = heldOp;
    end else if (ctrl.selTest) begin
      activeOp = testOp;
    end else begin
      activeOp = haltOp;
    end
  end

  for (genvar i = 0; i < AUX_W; i++) begin : g_aux
    if (i == AUX_GATED) begin : g_gated
      assign auxEff[i] = auxIn[i] & aux2Enable;
    end else begin : g_plain
      assign auxEff[i] = auxIn[i];
    end
  end

  assign keyAny  = |keyIn;
  assign keyLow  = |keyIn[KEY_SPLIT-1:0];
  assign keyHigh = |keyIn[KEY_SPLIT +: HIGH_W];
  assign baseCode = activeOp[BASE_W-1:0];

  always_comb begin
    unique case (baseCode)
      CODE_KEY_ALL:  baseHit = keyAny;
      CODE_KEY_LOW:  baseHit = keyLow;
      CODE_KEY_HIGH: baseHit = keyHigh;
      CODE_TIMER:    baseHit = timerZero;
      default:       baseHit = 1'b0;
    endcase
  end

  assign auxHit   = activeOp[OP_W-1] & (|auxEff);
  assign condTrue = baseHit | auxHit;
endmodule

// File: rtl/wfc_control.sv
module wfc_control
  import wfc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     testStb,
  input  logic     haltStb,
  input  logic     condTrue,
  output wfcCtrl_t ctrl,
  output logic     statusFlag,
  output logic     standby
);
  wfcState_t state;
  wfcState_t stateNext;
  logic      flagReg;
  logic      flagNext;
  logic      sleeping;

  assign sleeping = (state == ST_SLEEP);

  always_comb begin
    ctrl.selLatched = sleeping;
    ctrl.selTest    = testStb;
    ctrl.loadOp     = 1'b0;
    stateNext       = state;
    flagNext        = flagReg;
    if (sleeping) begin
      if (condTrue) begin
        stateNext = ST_RUN;
        flagNext  = 1'b1;
      end
    end else if (testStb) begin
      flagNext = condTrue;
    end else if (haltStb) begin
      if (condTrue) begin
        flagNext = 1'b1;
      end else if (flagReg) begin
        flagNext = 1'b0;
      end else begin
        stateNext   = ST_SLEEP;
        ctrl.loadOp = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      flagReg <= 1'b0;
    end else begin
      state   <= stateNext;
      flagReg <= flagNext;
    end
  end

  assign statusFlag = flagReg;
  assign standby    = sleeping;
endmodule

// File: rtl/wake_flag_ctrl.sv
module wake_flag_ctrl
  import wfc_pkg::*;
#(
  parameter int KEY_W     = 6,
  parameter int KEY_SPLIT = 3,
  parameter int AUX_W     = 3,
  parameter int AUX_GATED = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             testStb,
  input  logic [3:0]       testOp,
  input  logic             haltStb,
  input  logic [3:0]       haltOp,
  input  logic [KEY_W-1:0] keyIn,
  input  logic [AUX_W-1:0] auxIn,
  input  logic             timerZero,
  input  logic             aux2Enable,
  output logic             statusFlag,
  output logic             standby
);
  wfcCtrl_t ctrl;
  logic     condTrue;

  wfc_datapath #(
    .KEY_W(KEY_W), .KEY_SPLIT(KEY_SPLIT), .AUX_W(AUX_W), .AUX_GATED(AUX_GATED)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .testOp(testOp), .haltOp(haltOp),
    .keyIn(keyIn), .auxIn(auxIn), .timerZero(timerZero),
    .aux2Enable(aux2Enable), .condTrue(condTrue)
  );

  wfc_control u_ctl (
    .clk(clk), .rst(rst), .testStb(testStb), .haltStb(haltStb),
    .condTrue(condTrue), .ctrl(ctrl), .statusFlag(statusFlag),
    .standby(standby)
  );
endmodule

// File: rtl/wake_flag_ctrl_chk.sv
module wake_flag_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic testStb,
  input logic haltStb,
  input logic condTrue,
  input logic statusFlag,
  input logic standby
);
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!statusFlag && !standby));

  assert_test_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!standby && testStb) |=> (statusFlag == $past(condTrue) && !standby));

  assert_halt_true_R6: assert property (@(posedge clk) disable iff (rst)
    (!standby && !testStb && haltStb && condTrue) |=> (statusFlag && !standby));

  assert_halt_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!standby && !testStb && haltStb && !condTrue && statusFlag)
      |=> (!statusFlag && !standby));

  assert_halt_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    (!standby && !testStb && haltStb && !condTrue && !statusFlag)
      |=> (standby && !statusFlag));

  assert_wake_R9: assert property (@(posedge clk) disable iff (rst)
    (standby && condTrue) |=> (!standby && statusFlag));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (standby && !condTrue) |=> (standby && !statusFlag));

  assert_exit_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(standby) |-> statusFlag);
endmodule

bind wake_flag_ctrl wake_flag_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .testStb(testStb), .haltStb(haltStb),
  .condTrue(condTrue), .statusFlag(statusFlag), .standby(standby)
);

// File: tb/wake_flag_ctrl_bench.sv
module wake_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       testStb, haltStb;
  logic [3:0] testOp, haltOp;
  logic [5:0] keyIn;
  logic [2:0] auxIn;
  logic       timerZero, aux2Enable;
  logic       statusFlag, standby;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_flag_ctrl u_wake_flag_ctrl (
    .clk(clk), .rst(rst), .testStb(testStb), .testOp(testOp),
    .haltStb(haltStb), .haltOp(haltOp), .keyIn(keyIn), .auxIn(auxIn),
    .timerZero(timerZero), .aux2Enable(aux2Enable),
    .statusFlag(statusFlag), .standby(standby)
  );

  function automatic bit expCond(input logic [3:0] op, input logic [5:0] k,
                                 input logic [2:0] a, input logic tz,
                                 input logic en);
    bit base;
    case (op[2:0])
      3'b000:  base = |k;
      3'b011:  base = |k[2:0];
      3'b110:  base = |k[5:3];
      3'b101:  base = tz;
      default: base = 1'b0;
    endcase
    return base | (op[3] & (a[0] | a[1] | (a[2] & en)));
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    testStb = 0; haltStb = 0; testOp = 0; haltOp = 0;
    keyIn = 0; auxIn = 0; timerZero = 0; aux2Enable = 0;
  endtask

  task automatic doTest(input logic [3:0] op);
    testOp = op; testStb = 1; tick(); testStb = 0;
  endtask

  task automatic doHalt(input logic [3:0] op);
    haltOp = op; haltStb = 1; tick(); haltStb = 0;
  endtask

  task automatic t_reset();
    idle(); rst = 1; tick(); tick();
    check(statusFlag == 0, "R1 flag", statusFlag, 0);
    check(standby == 0, "R1 standby", standby, 0);
    rst = 0; tick();
  endtask

  task automatic t_codes();
    logic [5:0] keyPats [5] = '{6'h00, 6'h01, 6'h04, 6'h08, 6'h20};
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 5; p++) begin
        for (int tz = 0; tz < 2; tz++) begin
          bit e;
          keyIn = keyPats[p]; timerZero = tz[0]; auxIn = 0;
          e = expCond({1'b0, c[2:0]}, keyIn, auxIn, timerZero, aux2Enable);
          doTest({1'b0, c[2:0]});
          check(statusFlag == e, "R2 R3 code", statusFlag, e);
        end
      end
    end
    keyIn = 0; timerZero = 0;
  endtask

  task automatic t_aux();
    for (int a = 0; a < 8; a++) begin
      for (int en = 0; en < 2; en++) begin
        bit e;
        auxIn = a[2:0]; aux2Enable = en[0];
        e = expCond(4'b1111, keyIn, auxIn, timerZero, aux2Enable);
        doTest(4'b1111);
        check(statusFlag == e, "R4 R5 aux", statusFlag, e);
        e = expCond(4'b0111, keyIn, auxIn, timerZero, aux2Enable);
        doTest(4'b0111);
        check(statusFlag == e, "R4 no aux without bit3", statusFlag, e);
      end
    end
    auxIn = 0; aux2Enable = 0;
  endtask

  task automatic t_halt_true();
    doTest(4'b0111);
    keyIn = 6'h02;
    doHalt(4'b0011);
    check(statusFlag == 1, "R6 flag", statusFlag, 1);
    check(standby == 0, "R6 standby", standby, 0);
    keyIn = 0;
  endtask

  task automatic t_halt_clear();
    timerZero = 1; doTest(4'b0101); timerZero = 0;
    check(statusFlag == 1, "R2 setup", statusFlag, 1);
    doHalt(4'b0101);
    check(statusFlag == 0, "R7 flag", statusFlag, 0);
    check(standby == 0, "R7 standby", standby, 0);
  endtask

  task automatic t_standby_timer();
    doTest(4'b0111);
    doHalt(4'b0101);
    check(standby == 1, "R8 standby", standby, 1);
    check(statusFlag == 0, "R8 flag", statusFlag, 0);
    keyIn = 6'h3F; haltOp = 4'b0000; testOp = 4'b0000; tick();
    check(standby == 1, "R10 held op", standby, 1);
    doTest(4'b0000);
    check(statusFlag == 0 && standby == 1, "R11 test ignored", statusFlag, 0);
    doHalt(4'b0000);
    check(statusFlag == 0 && standby == 1, "R11 halt ignored", standby, 1);
    timerZero = 1; tick();
    check(standby == 0, "R9 standby", standby, 0);
    check(statusFlag == 1, "R9 flag", statusFlag, 1);
    timerZero = 0; keyIn = 0; tick();
  endtask

  task automatic t_standby_aux2();
    doTest(4'b0111);
    auxIn = 3'b100; aux2Enable = 0;
    doHalt(4'b1111);
    check(standby == 1, "R5 gated aux2 sleeps", standby, 1);
    tick();
    check(standby == 1, "R5 gated aux2 holds", standby, 1);
    aux2Enable = 1; tick();
    check(standby == 0 && statusFlag == 1, "R9 R5 aux2 wake", standby, 0);
    auxIn = 0; aux2Enable = 0;
  endtask

  task automatic t_priority();
    doTest(4'b0111);
    testOp = 4'b0111; haltOp = 4'b0111; testStb = 1; haltStb = 1; tick();
    testStb = 0; haltStb = 0;
    check(standby == 0, "R12 standby", standby, 0);
    check(statusFlag == 0, "R12 flag", statusFlag, 0);
    timerZero = 1;
    testOp = 4'b0101; haltOp = 4'b0111; testStb = 1; haltStb = 1; tick();
    testStb = 0; haltStb = 0; timerZero = 0;
    check(statusFlag == 1 && standby == 0, "R12 test wins", statusFlag, 1);
  endtask

  initial begin
    rst = 1; idle();
    t_reset();
    t_codes();
    t_aux();
    t_halt_true();
    t_halt_clear();
    t_standby_timer();
    t_standby_aux2();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule